// File: doc/BRIEF.md
# Write-Protected GPIO Register Front End

This block sits between a simple 32-bit register port and the configuration registers of a GPIO port. It decodes byte offsets inside a 4 KiB window, sorts every access into a normal, read-only, write-only or invalid register, and sends permitted writes on to the register storage behind it as a one-cycle strobe carrying the offset and the data. Reads of normal registers return the value the storage presents for the requested offset. Write-only registers read as zero. Invalid offsets read as zero and raise an error.

The block also owns a write-protection lock made of two key registers. While unlocked, any write to either key register arms the lock. While locked, every write outside the two key registers is dropped with an error. Unlocking is a two-step sequence: a second-key value is written first, then a first-key value; any other value leaves the lock armed. The pin resolution and event logic behind the registers are not part of this block.

Top module: `regguard_top`

## Requirements
- R1: After reset the block is unlocked, offset 0x00 reads 0, and neither `rsp_valid` nor `cfg_wr_valid` is high.
- R2: `req_ready` is always 1; every cycle with `req_valid` high produces exactly one response, with `rsp_valid` high in the next cycle, and no response appears otherwise.
- R3: While unlocked, a write to a writable offset (0x08, 0x0C, 0x10, 0x14, 0x1C, 0x20, 0x28, 0x2C, 0x40, 0x44, 0x48, 0x4C, 0x58, 0x68, 0x6C, 0x70, 0x74) gives a one-cycle `cfg_wr_valid` in the response cycle, with `cfg_wr_off` equal to the byte offset, `cfg_wr_data` equal to the written data, and no error.
- R4: While unlocked, a write of any value to offset 0x00 or 0x7C arms the lock, clears the second key to 0, produces no strobe and no error; offset 0x00 then reads 1.
- R5: While locked, a write to any offset other than 0x00 and 0x7C produces no strobe and an error; reads are not affected by the lock.
- R6: While locked, a write to 0x7C stores the second key; writing 0xC0DEFA73 to 0x00 unlocks and clears both keys only when the second key holds 0xC0DE1248. Any other value at 0x00, or a missing or wrong second key, leaves the block locked with no error.
- R7: A read of a readable offset (0x04, 0x08, 0x0C, 0x10, 0x14, 0x1C, 0x20, 0x28, 0x2C, 0x40, 0x4C, 0x58) returns `cfg_rd_data` as presented during the request cycle, with no error; a read of 0x00 returns 1 when locked and 0 when unlocked.
- R8: Reads of the write-only offsets 0x44, 0x48, 0x68, 0x6C, 0x70, 0x74 and 0x7C return 0 with no error.
- R9: A write to the input-data offset 0x04 produces no strobe and an error.
- R10: An offset that is not a multiple of 4, or that is not in the map above, reads 0 with an error and, when written, produces no strobe and an error.
- R11: `rsp_err` is high only in a response cycle, so an error is a pulse of exactly one cycle per faulty access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Always 1: each access is taken at once |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset inside the window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response of the access taken in the previous cycle |
| rsp_rdata | output | 32 | Read data (0 for writes) |
| rsp_err | output | 1 | Error pulse for a faulty access |
| cfg_rd_data | input | 32 | Register storage value for `req_addr` |
| cfg_wr_valid | output | 1 | Write strobe to register storage |
| cfg_wr_off | output | ADDR_W | Byte offset of the strobed write |
| cfg_wr_data | output | 32 | Data of the strobed write |

## Verification
The bench builds the block with the default ADDR_W of 12, so the whole 4 KiB window is addressable and the highest word offset 0xFFC, the unaligned offsets and the holes in the map can all be hit as invalid accesses. With this width every mapped offset is exercised for strobes, read-back and write-only zeros, and the lock is walked through arming, wrong first keys, wrong and missing second keys, a correct unlock, and re-arming after an unlock to show the second key was cleared.

// File: rtl/regguard_pkg.sv
package regguard_pkg;

    localparam int unsigned DATA_W = 32;
    localparam logic [DATA_W-1:0] KEY_FIRST  = 32'hC0DE_FA73;
    localparam logic [DATA_W-1:0] KEY_SECOND = 32'hC0DE_1248;

    // Offsets whose position is fixed by neighbouring logic
    localparam logic [31:0] OFF_KEY_A = 32'h00;
    localparam logic [31:0] OFF_KEY_B = 32'h7C;

    typedef enum logic [1:0] {
        KIND_RW  = 2'd0,
        KIND_RO  = 2'd1,
        KIND_WO  = 2'd2,
        KIND_BAD = 2'd3
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e kind;
        logic      key_a;
        logic      key_b;
    } dec_t;

    function automatic dec_t classify(input logic [31:0] off);
        dec_t d;
        d.kind  = KIND_BAD;
        d.key_a = 1'b0;
        d.key_b = 1'b0;
        case (off)
            OFF_KEY_A: begin
                d.kind  = KIND_RW;
                d.key_a = 1'b1;
            end
            OFF_KEY_B: begin
                d.kind  = KIND_WO;
                d.key_b = 1'b1;
            end
            32'h04:
                d.kind = KIND_RO;
            32'h08, 32'h0C, 32'h10, 32'h14, 32'h1C, 32'h20,
            32'h28, 32'h2C, 32'h40, 32'h4C, 32'h58:
                d.kind = KIND_RW;
            32'h44, 32'h48, 32'h68, 32'h6C, 32'h70, 32'h74:
                d.kind = KIND_WO;
            default:
                d.kind = KIND_BAD;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/regguard_decode.sv
module regguard_decode
    import regguard_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    localparam int unsigned PAD_W = 32 - ADDR_W;

    logic [31:0] wide_off;

    generate
        if (PAD_W > 0) begin : g_pad
            assign wide_off = {{PAD_W{1'b0}}, addr};
        end else begin : g_nopad
            assign wide_off = addr[31:0];
        end
    endgenerate

    // Misaligned offsets match no case item and fall into KIND_BAD
    always_comb dec = classify(wide_off);
endmodule

// File: rtl/regguard_lock.sv
module regguard_lock
    import regguard_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              hit_a,
    input  logic              hit_b,
    input  logic [DATA_W-1:0] wdata,
    output logic              locked
);
    logic              lock_q;
    logic [DATA_W-1:0] key_b_q;
    logic              key_ok;

    assign key_ok = (key_b_q == KEY_SECOND) && (wdata == KEY_FIRST);
    assign locked = lock_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q  <= 1'b0;
            key_b_q <= '0;
        end else if (wr_en) begin
            if (!lock_q) begin
                if (hit_a || hit_b) begin
                    lock_q  <= 1'b1;
                    key_b_q <= '0;
                end
            end else if (hit_b) begin
                key_b_q <= wdata;
            end else if (hit_a && key_ok) begin
                lock_q  <= 1'b0;
                key_b_q <= '0;
            end
        end
    end
endmodule

// File: rtl/regguard_top.sv
module regguard_top
    import regguard_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              rsp_err,
    input  logic [31:0]       cfg_rd_data,
    output logic              cfg_wr_valid,
    output logic [ADDR_W-1:0] cfg_wr_off,
    output logic [31:0]       cfg_wr_data
);
    dec_t        dec;
    logic        lock_q;
    logic        wr_acc;
    logic        rd_acc;
    logic        key_hit;
    logic        pass_wr;
    logic        err_nxt;
    logic [31:0] rdata_nxt;

    regguard_decode #(.ADDR_W(ADDR_W)) dec_i (
        .addr (req_addr),
        .dec  (dec)
    );

    regguard_lock lock_i (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_acc),
        .hit_a  (dec.key_a),
        .hit_b  (dec.key_b),
        .wdata  (req_wdata),
        .locked (lock_q)
    );

    assign req_ready = 1'b1;
    assign wr_acc    = req_valid && req_write;
    assign rd_acc    = req_valid && !req_write;
    assign key_hit   = dec.key_a || dec.key_b;

    always_comb begin
        pass_wr = wr_acc && !lock_q && !key_hit &&
                  (dec.kind == KIND_RW || dec.kind == KIND_WO);
        err_nxt = (req_valid && dec.kind == KIND_BAD) ||
                  (wr_acc && dec.kind == KIND_RO) ||
                  (wr_acc && lock_q && !key_hit);
        rdata_nxt = '0;
        if (rd_acc && (dec.kind == KIND_RW || dec.kind == KIND_RO)) begin
            rdata_nxt = dec.key_a ? {31'b0, lock_q} : cfg_rd_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid    <= 1'b0;
            rsp_rdata    <= '0;
            rsp_err      <= 1'b0;
            cfg_wr_valid <= 1'b0;
            cfg_wr_off   <= '0;
            cfg_wr_data  <= '0;
        end else begin
            rsp_valid    <= req_valid;
            rsp_rdata    <= rdata_nxt;
            rsp_err      <= err_nxt;
            cfg_wr_valid <= pass_wr;
            if (pass_wr) begin
                cfg_wr_off  <= req_addr;
                cfg_wr_data <= req_wdata;
            end
        end
    end
endmodule

// File: rtl/regguard_chk.sv
module regguard_chk #(
    parameter int unsigned ADDR_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic              cfg_wr_valid,
    input logic              lock_st
);
    logic key_addr;
    assign key_addr = (req_addr == ADDR_W'('h00)) || (req_addr == ADDR_W'('h7C));

    assert_resp_follows_R2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    assert_no_spurious_R2: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    assert_err_in_resp_R11: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> rsp_valid);

    assert_strobe_clean_R3: assert property (@(posedge clk) disable iff (rst)
        cfg_wr_valid |-> (rsp_valid && !rsp_err));

    assert_arm_lock_R4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && !lock_st && key_addr) |=> lock_st);

    assert_block_write_R5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && lock_st && !key_addr) |=> (rsp_err && !cfg_wr_valid));
endmodule

bind regguard_top regguard_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_addr     (req_addr),
    .rsp_valid    (rsp_valid),
    .rsp_err      (rsp_err),
    .cfg_wr_valid (cfg_wr_valid),
    .lock_st      (lock_q)
);

// File: tb/regguard_top_tb.sv
module regguard_top_tb_top;
    localparam int unsigned AW = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic          rsp_valid;
    logic [31:0]   rsp_rdata;
    logic          rsp_err;
    logic [31:0]   cfg_rd_data;
    logic          cfg_wr_valid;
    logic [AW-1:0] cfg_wr_off;
    logic [31:0]   cfg_wr_data;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    // Register storage stand-in: value depends on offset only
    assign cfg_rd_data = 32'h5A00_0000 | {20'b0, req_addr};

    regguard_top #(.ADDR_W(AW)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_write    (req_write),
        .req_addr     (req_addr),
        .req_wdata    (req_wdata),
        .rsp_valid    (rsp_valid),
        .rsp_rdata    (rsp_rdata),
        .rsp_err      (rsp_err),
        .cfg_rd_data  (cfg_rd_data),
        .cfg_wr_valid (cfg_wr_valid),
        .cfg_wr_off   (cfg_wr_off),
        .cfg_wr_data  (cfg_wr_data)
    );

    typedef struct {
        logic [31:0]   rdata;
        bit            err;
        bit            strobe;
        logic [AW-1:0] off;
        logic [31:0]   wdata;
        string         tag;
    } exp_t;

    exp_t sb[$];

    task automatic note(input bit ok, input string tag, input string what);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s", tag, what);
        end
    endtask

    task automatic access(input bit w, input logic [AW-1:0] a, input logic [31:0] d,
                          input logic [31:0] er, input bit ee, input bit es,
                          input string tag);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1;
        req_write = w;
        req_addr  = a;
        req_wdata = d;
        e.rdata = er; e.err = ee; e.strobe = es; e.off = a; e.wdata = d; e.tag = tag;
        sb.push_back(e);
        @(posedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    // Monitor: compares each response against the scoreboard head
    always @(negedge clk) begin
        if (!rst) begin
            if (rsp_valid) begin
                if (sb.size() == 0) begin
                    note(1'b0, "R2", "response with nothing outstanding (actual 1 expected 0)");
                end else begin
                    exp_t e;
                    bit ok;
                    e = sb.pop_front();
                    ok = (rsp_rdata == e.rdata) && (rsp_err == e.err) &&
                         (cfg_wr_valid == e.strobe) &&
                         (!e.strobe || (cfg_wr_off == e.off && cfg_wr_data == e.wdata));
                    note(ok, e.tag, $sformatf(
                        "off %h actual rdata=%h err=%0d stb=%0d off=%h data=%h expected rdata=%h err=%0d stb=%0d data=%h",
                        e.off, rsp_rdata, rsp_err, cfg_wr_valid, cfg_wr_off, cfg_wr_data,
                        e.rdata, e.err, e.strobe, e.wdata));
                end
            end else if (cfg_wr_valid || rsp_err) begin
                note(1'b0, "R11", $sformatf("strobe/err outside response actual %0d/%0d expected 0/0",
                     cfg_wr_valid, rsp_err));
            end
        end
    end

    function automatic logic [31:0] rd_exp(input logic [AW-1:0] a);
        return 32'h5A00_0000 | {20'b0, a};
    endfunction

    localparam logic [AW-1:0] RW_OFFS [11] = '{12'h08, 12'h0C, 12'h10, 12'h14, 12'h1C,
                                               12'h20, 12'h28, 12'h2C, 12'h40, 12'h4C, 12'h58};
    localparam logic [AW-1:0] WO_OFFS [6]  = '{12'h44, 12'h48, 12'h68, 12'h6C, 12'h70, 12'h74};

    localparam logic [31:0] KA = 32'hC0DE_FA73;
    localparam logic [31:0] KB = 32'hC0DE_1248;

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: run hung (actual timeout expected completion)");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1: reset state at the ports
        note(rsp_valid == 1'b0 && cfg_wr_valid == 1'b0 && req_ready == 1'b1, "R1",
             $sformatf("after reset actual valid=%0d stb=%0d ready=%0d expected 0/0/1",
                       rsp_valid, cfg_wr_valid, req_ready));
        access(0, 12'h00, 0, 32'd0, 0, 0, "R1");

        // R3: writes to writable offsets while unlocked, back to back
        for (int i = 0; i < 11; i++)
            access(1, RW_OFFS[i], 32'h1000_0000 + 32'(i), 0, 0, 1, "R3");
        for (int i = 0; i < 6; i++)
            access(1, WO_OFFS[i], 32'h2000_0000 + 32'(i), 0, 0, 1, "R3");

        // R7: readable offsets return storage data
        for (int i = 0; i < 11; i++)
            access(0, RW_OFFS[i], 0, rd_exp(RW_OFFS[i]), 0, 0, "R7");
        access(0, 12'h04, 0, rd_exp(12'h04), 0, 0, "R7");

        // R8: write-only offsets read 0
        for (int i = 0; i < 6; i++)
            access(0, WO_OFFS[i], 0, 0, 0, 0, "R8");
        access(0, 12'h7C, 0, 0, 0, 0, "R8");

        // R9: input-data offset is read-only
        access(1, 12'h04, 32'hFFFF_FFFF, 0, 1, 0, "R9");

        // R10: unmapped / misaligned / top of window
        access(0, 12'h18, 0, 0, 1, 0, "R10");
        access(0, 12'h0E, 0, 0, 1, 0, "R10");
        access(0, 12'hFFC, 0, 0, 1, 0, "R10");
        access(1, 12'h18, 32'h1234, 0, 1, 0, "R10");
        access(1, 12'h0A, 32'h1234, 0, 1, 0, "R10");
        access(1, 12'h80, 32'h1234, 0, 1, 0, "R10");

        // R11: error pulse lasts one cycle
        repeat (2) @(negedge clk);
        note(rsp_err == 1'b0, "R11", $sformatf("idle after error actual %0d expected 0", rsp_err));

        // R4: arm the lock through the second key register
        access(1, 12'h7C, 32'h0000_0123, 0, 0, 0, "R4");
        access(0, 12'h00, 0, 32'd1, 0, 0, "R4");

        // R5: writes blocked while locked, reads unaffected
        access(1, 12'h08, 32'hDEAD_BEEF, 0, 1, 0, "R5");
        access(1, 12'h44, 32'h1, 0, 1, 0, "R5");
        access(1, 12'h18, 32'h1, 0, 1, 0, "R5");
        access(0, 12'h08, 0, rd_exp(12'h08), 0, 0, "R5");
        access(0, 12'h44, 0, 0, 0, 0, "R5");

        // R6: first key without second key (cleared on arming)
        access(1, 12'h00, KA, 0, 0, 0, "R6");
        access(0, 12'h00, 0, 32'd1, 0, 0, "R6");
        // wrong second key
        access(1, 12'h7C, 32'h1234, 0, 0, 0, "R6");
        access(1, 12'h00, KA, 0, 0, 0, "R6");
        access(0, 12'h00, 0, 32'd1, 0, 0, "R6");
        // right second key, wrong first key, then right first key
        access(1, 12'h7C, KB, 0, 0, 0, "R6");
        access(1, 12'h00, 32'h0, 0, 0, 0, "R6");
        access(0, 12'h00, 0, 32'd1, 0, 0, "R6");
        access(1, 12'h00, KA, 0, 0, 0, "R6");
        access(0, 12'h00, 0, 32'd0, 0, 0, "R6");
        access(1, 12'h08, 32'hCAFE_0001, 0, 0, 1, "R6");

        // R4 through the first key register; R6 second key was cleared by unlock
        access(1, 12'h00, 32'h5555, 0, 0, 0, "R4");
        access(0, 12'h00, 0, 32'd1, 0, 0, "R4");
        access(1, 12'h00, KA, 0, 0, 0, "R6");
        access(0, 12'h00, 0, 32'd1, 0, 0, "R6");
        access(1, 12'h7C, KB, 0, 0, 0, "R6");
        access(1, 12'h00, KA, 0, 0, 0, "R6");
        access(0, 12'h00, 0, 32'd0, 0, 0, "R6");
        access(1, 12'h58, 32'h0000_00FF, 0, 0, 1, "R3");

        repeat (3) @(negedge clk);
        note(sb.size() == 0, "R2", $sformatf("outstanding responses actual %0d expected 0", sb.size()));
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule